// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two N-bit two's complement operands over several clock cycles and returns the exact 2N-bit signed product. A pulse on `start` while the block is idle captures both operands. The block then works through the multiplier one bit per cycle. Each cycle it looks only at the lowest bit of a shifting multiplier register. If that bit is 1, it adds the multiplicand into an N-bit accumulator. The accumulator and the multiplier register then shift right together as one 2N-bit pair, so the low half of the product collects in the multiplier register.

The multiplier's sign bit carries negative weight. For that reason the last cycle subtracts the multiplicand instead of adding it, and one more shift follows. The adder/subtractor is only N bits wide, so its sum can overflow. The block repairs this in the bit it shifts into the accumulator MSB. That bit is not taken by sign extension of the N-bit sum. It is derived from the operand signs and from whether any 1 bit of the multiplier has been seen yet.

The caller waits for a single-cycle `done` pulse. `product` stays valid from that pulse until the next accepted start.

Top module: `shiftadd_smul`

## Requirements
- R1: A `start` sampled high on a rising edge while `busy` is low is accepted, and `busy` is high from that edge on.
- R2: At `done`, `product` equals the exact two's complement product of the operands sampled with the accepted start, sign-extended to 2N bits, for every operand pair.
- R3: If start is accepted at rising edge E, `done` is high in the cycle after edge E+N+1. That is N+2 cycles of latency, with no early and no late completion.
- R4: `done` is high for exactly one cycle. After the next edge both `done` and `busy` are low.
- R5: A `start` that arrives while `busy` is high, with any operand values, is ignored. It changes neither the product nor the latency of the operation in progress.
- R6: After `done`, `product` holds its value while the block is idle and `start` stays low, whatever the operand inputs do.
- R7: While `rst` is high (synchronous, active high), the outputs after each edge are `busy` = 0, `done` = 0 and `product` = 0.
- R8: For N = 4, multiplicand 4'b1010 (-6) times multiplier 4'b1100 (-4) gives product 8'b0001_1000 (+24). This case exercises the final subtract step.
- R9: Multiplying the most negative value by itself gives +2^(2N-2), with bit 2N-2 set and all other bits clear. For N = 4 that is 8'b0100_0000. The N-bit subtraction in the last step overflows here, and the result must still be correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; taken only while idle |
| multiplicand | input | N | Two's complement multiplicand, sampled with an accepted start |
| multiplier | input | N | Two's complement multiplier, sampled with an accepted start |
| busy | output | 1 | High from acceptance until the cycle after `done` |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
For N = 4 the bench sweeps all 256 operand pairs. This covers adds that overflow the N-bit accumulator, a subtract that overflows in the last step, zero operands that must not leak a sign bit into the result, and every sign combination. Latency is checked on every pair, which separates a counter that is off by one from a correct one.

A wider N = 8 instance takes the cross product of its extreme values together with a pseudo-random set of pairs. This shows that the repair of the filled-in bit does not depend on the width. Starts and changing operands are also injected in the middle of an operation and while the block is idle. These show that only an accepted start can disturb the product.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_CORR,
        ST_DONE
    } smul_state_e;

    // commands from the sequencer to the datapath
    typedef struct packed {
        logic capture;   // latch operands, clear accumulator
        logic step;      // ordinary add-and-shift cycle
        logic corr;      // sign-bit cycle: subtract-and-shift
    } smul_cmd_t;

    // Bit entering the accumulator MSB on a shift.
    // Ordinary cycle: the partial sum is zero until a 1 bit has been seen,
    //   afterwards it carries the multiplicand sign.
    // Correction cycle: the sign of the whole product, zero if either
    //   operand is zero (multiplier nonzero <=> seen or its sign bit set).
    function automatic logic fill_bit(input logic corr,
                                      input logic seen,
                                      input logic add_now,
                                      input logic mc_sign,
                                      input logic mc_zero);
        logic any_one;
        any_one = seen | add_now;
        if (corr)
            return any_one & ~mc_zero & (mc_sign ^ add_now);
        else
            return any_one & mc_sign;
    endfunction

endpackage

// File: rtl/smul_addsub.sv
module smul_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,   // 0 = add, 1 = subtract
    output logic [W-1:0] sum
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {W{sub}};
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/smul_downcnt.sv
module smul_downcnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last      // current count is one: this decrement reaches zero
);
    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec && count != '0)
            count <= count - 1'b1;
    end

    assign last = (count == {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      last,
    output smul_cmd_t cmd,
    output logic      cnt_load,
    output logic      cnt_dec,
    output logic      busy,
    output logic      done
);
    smul_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_LOAD;
            ST_LOAD: state_nx = ST_STEP;
            ST_STEP: if (last) state_nx = ST_CORR;
            ST_CORR: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd.capture = (state == ST_IDLE) && start;
        cmd.step    = (state == ST_STEP);
        cmd.corr    = (state == ST_CORR);
        cnt_load    = (state == ST_LOAD);
        cnt_dec     = (state == ST_STEP);
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
    end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  smul_cmd_t      cmd,
    input  logic [N-1:0]   mcand_in,
    input  logic [N-1:0]   mplier_in,
    output logic [2*N-1:0] product
);
    logic [N-1:0] acc;
    logic [N-1:0] mq;
    logic [N-1:0] mcand;
    logic         seen;

    logic         add_now;
    logic [N-1:0] sum;
    logic [N-1:0] acc_upd;
    logic         fill;

    assign add_now = mq[0];

    smul_addsub #(.W(N)) u_addsub (
        .a   (acc),
        .b   (mcand),
        .sub (cmd.corr),
        .sum (sum)
    );

    always_comb begin
        acc_upd = add_now ? sum : acc;
        fill    = fill_bit(cmd.corr, seen, add_now, mcand[N-1], mcand == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            mq    <= '0;
            mcand <= '0;
            seen  <= 1'b0;
        end else if (cmd.capture) begin
            acc   <= '0;
            mq    <= mplier_in;
            mcand <= mcand_in;
            seen  <= 1'b0;
        end else if (cmd.step || cmd.corr) begin
            {acc, mq} <= {fill, acc_upd, mq[N-1:1]};
            seen      <= seen | add_now;
        end
    end

    assign product = {acc, mq};
endmodule

// File: rtl/shiftadd_smul.sv
module shiftadd_smul
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int CW = (N <= 2) ? 1 : $clog2(N);
    localparam logic [CW-1:0] STEPS = CW'(N - 1);

    smul_cmd_t cmd;
    logic      cnt_load;
    logic      cnt_dec;
    logic      last;

    smul_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last     (last),
        .cmd      (cmd),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .busy     (busy),
        .done     (done)
    );

    smul_downcnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (STEPS),
        .dec      (cnt_dec),
        .last     (last)
    );

    smul_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .product   (product)
    );
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   multiplicand,
    input logic [N-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    logic [N-1:0]          cap_a, cap_b;
    logic [15:0]           lat;
    logic                  rst_q;
    logic signed [2*N-1:0] ext_a, ext_b, ref_p;

    always_comb begin
        ext_a = {{N{cap_a[N-1]}}, cap_a};
        ext_b = {{N{cap_b[N-1]}}, cap_b};
        ref_p = ext_a * ext_b;
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            cap_a <= '0;
            cap_b <= '0;
            lat   <= '0;
        end else if (start && !busy) begin
            cap_a <= multiplicand;
            cap_b <= multiplier;
            lat   <= 16'd1;
        end else if (lat != 16'd0 && lat != 16'hFFFF) begin
            lat <= lat + 16'd1;
        end
    end

    // R7
    always_ff @(posedge clk) begin
        if (rst_q)
            reset_state_chk: assert (!busy && !done && product == '0);
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_p));

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat == 16'(N + 2)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind shiftadd_smul smul_chk #(.N(N)) u_smul_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/test_shiftadd_smul.sv
module test_shiftadd_smul;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;   // 100 MHz

    int checks = 0;
    int errors = 0;

    // ---------------- N = 4 instance ----------------
    logic       start4 = 1'b0;
    logic [3:0] mc4 = '0, mp4 = '0;
    logic       busy4, done4;
    logic [7:0] prod4;

    shiftadd_smul #(.N(4)) i_shiftadd_smul (
        .clk(clk), .rst(rst), .start(start4),
        .multiplicand(mc4), .multiplier(mp4),
        .busy(busy4), .done(done4), .product(prod4)
    );

    // ---------------- N = 8 instance ----------------
    logic        start8 = 1'b0;
    logic [7:0]  mc8 = '0, mp8 = '0;
    logic        busy8, done8;
    logic [15:0] prod8;

    shiftadd_smul #(.N(8)) i_shiftadd_smul_w8 (
        .clk(clk), .rst(rst), .start(start8),
        .multiplicand(mc8), .multiplier(mp8),
        .busy(busy8), .done(done8), .product(prod8)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one N=4 operation; poke=1 injects a start with other operands mid-run (R5)
    task automatic run4(input logic [3:0] a, input logic [3:0] b, input bit poke,
                        output logic [7:0] p, output int lat);
        @(negedge clk);
        start4 = 1'b1; mc4 = a; mp4 = b;
        @(negedge clk);
        start4 = 1'b0;
        lat = 1;
        check(busy4 == 1'b1, "R1", "busy after accept", longint'(busy4), 1);
        while (!done4 && lat < 60) begin
            if (poke && lat == 2) begin
                start4 = 1'b1; mc4 = ~a; mp4 = a ^ b ^ 4'h5;
            end else begin
                start4 = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start4 = 1'b0;
        p = prod4;
        @(negedge clk);
        check(!done4 && !busy4, "R4", "done/busy after pulse",
              longint'({done4, busy4}), 0);
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b,
                        output logic [15:0] p, output int lat);
        @(negedge clk);
        start8 = 1'b1; mc8 = a; mp8 = b;
        @(negedge clk);
        start8 = 1'b0;
        lat = 1;
        while (!done8 && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        p = prod8;
    endtask

    function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
        int ia, ib;
        ia = int'($signed(a));
        ib = int'($signed(b));
        return 8'(ia * ib);
    endfunction

    function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
        int ia, ib;
        ia = int'($signed(a));
        ib = int'($signed(b));
        return 16'(ia * ib);
    endfunction

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  p4;
        logic [15:0] p8;
        logic [7:0]  held;
        int          lat;
        logic [7:0]  edges8 [6];
        logic [7:0]  ra, rb;

        // R7: reset state
        repeat (3) @(negedge clk);
        check(!busy4 && !done4 && prod4 == 8'h00, "R7", "reset outputs n4",
              longint'(prod4), 0);
        check(!busy8 && prod8 == 16'h0, "R7", "reset outputs n8",
              longint'(prod8), 0);
        rst = 1'b0;

        // R8: worked example -6 * -4
        run4(4'b1010, 4'b1100, 1'b0, p4, lat);
        check(p4 == 8'b0001_1000, "R8", "1010 x 1100", longint'(p4), 24);

        // R9: most negative squared
        run4(4'b1000, 4'b1000, 1'b0, p4, lat);
        check(p4 == 8'b0100_0000, "R9", "1000 x 1000", longint'(p4), 64);

        // R2 / R3: exhaustive sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run4(4'(a), 4'(b), 1'b0, p4, lat);
                check(p4 == ref4(4'(a), 4'(b)), "R2", $sformatf("a=%0d b=%0d", a, b),
                      longint'(p4), longint'(ref4(4'(a), 4'(b))));
                check(lat == 6, "R3", "latency n4", lat, 6);
            end
        end

        // R5: start with new operands while busy is ignored
        run4(4'b0111, 4'b1001, 1'b1, p4, lat);
        check(p4 == ref4(4'b0111, 4'b1001), "R5", "product under busy start",
              longint'(p4), longint'(ref4(4'b0111, 4'b1001)));
        check(lat == 6, "R5", "latency under busy start", lat, 6);
        run4(4'b1000, 4'b0111, 1'b1, p4, lat);
        check(p4 == ref4(4'b1000, 4'b0111), "R5", "product under busy start 2",
              longint'(p4), longint'(ref4(4'b1000, 4'b0111)));

        // R6: product holds while idle with moving operands
        held = prod4;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mc4 = 4'(k * 3); mp4 = 4'(15 - k);
        end
        @(negedge clk);
        check(prod4 == held && !busy4, "R6", "idle hold", longint'(prod4), longint'(held));

        // N = 8: extremes cross product
        edges8[0] = 8'h80; edges8[1] = 8'h7F; edges8[2] = 8'h00;
        edges8[3] = 8'hFF; edges8[4] = 8'h01; edges8[5] = 8'h81;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                run8(edges8[i], edges8[j], p8, lat);
                check(p8 == ref8(edges8[i], edges8[j]), "R2", "n8 extremes",
                      longint'(p8), longint'(ref8(edges8[i], edges8[j])));
                check(lat == 10, "R3", "latency n8", lat, 10);
            end
        end
        run8(8'h80, 8'h80, p8, lat);
        check(p8 == 16'h4000, "R9", "n8 most negative squared", longint'(p8), 16'h4000);

        // N = 8: pseudo-random pairs
        ra = 8'h5A; rb = 8'hC3;
        for (int n = 0; n < 400; n++) begin
            ra = {ra[6:0], ra[7] ^ ra[5] ^ ra[4] ^ ra[3]};
            rb = 8'(rb * 8'd13 + 8'd71);
            run8(ra, rb, p8, lat);
            check(p8 == ref8(ra, rb), "R2", "n8 random",
                  longint'(p8), longint'(ref8(ra, rb)));
        end

        // R7: reset after a run clears product
        run4(4'b0111, 4'b0111, 1'b0, p4, lat);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(prod4 == 8'h00 && !busy4 && !done4, "R7", "reset clears product",
              longint'(prod4), 0);
        rst = 1'b0;

        summary();
        $finish;
    end
endmodule